// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder with Compressed Test Mode

This block is the device side of a small dynamic memory with multiplexed addressing. A fast system clock samples the active-low row strobe, column strobe and write enable, together with the shared address bus and the single data input. From the sequence of strobe edges it works out the kind of each memory cycle: read, write, refresh with only the row strobe, or refresh with the column strobe before the row strobe. Reads and writes go to a small internal bit array. Refresh cycles leave the array alone; they are recognised and counted.

After reset the block waits a programmable start-up interval. It then needs a set number of refresh cycles before it raises its ready flag and accepts accesses. A column-before-row refresh with write enable low latches a parallel test mode. In that mode the two lowest column bits are ignored, so each access reaches four cells at once. A write fills all four cells with the data bit. A read returns one pass/fail bit that shows whether the four cells agree. That read result also appears one clock later than normal read data. A row-only refresh, or a column-before-row refresh with write enable high, ends the test mode.

Top module: `dram_cycle_decoder`

## Requirements
- R1: `ready` is low after reset. It rises only after STARTUP_CYC clocks have passed since reset release and then INIT_CYCLES refresh cycles of either kind have been seen. Refreshes that occur during the start-up interval do not count.
- R2: Once `ready` is high it stays high until reset.
- R3: A refresh is column-before-row when `cas_n` is already low at the sampled falling edge of `ras_n`. It writes no cell and does not enable `dq_oe`.
- R4: A refresh is row-only when `ras_n` falls with `cas_n` high and rises again with no `cas_n` fall between. It counts toward R1 and touches no cell.
- R5: The row is taken from `addr` when `ras_n` falls and the column when `cas_n` falls. Cell index is {row, column}. `we_n` low at the `cas_n` fall makes a write of `dq_in`, and high makes a read.
- R6: A normal read drives the stored bit with `dq_oe` high. The output becomes valid SYNC_STAGES+1 clocks after `cas_n` falls. `dq_oe` goes low once `cas_n` is high, and stays low through writes and refreshes.
- R7: A column-before-row refresh with `we_n` low sets `test_active`, but only while `ready` is high.
- R8: `test_active` stays set across any number of reads and writes.
- R9: A row-only refresh, or a column-before-row refresh with `we_n` high, clears `test_active`.
- R10: A test-mode read ignores column bits 1:0. It returns 1 when the four cells sharing the other address bits are all equal, and 0 otherwise.
- R11: A test-mode write stores `dq_in` into all four cells that differ only in column bits 1:0.
- R12: A test-mode read becomes valid exactly one clock later than a normal read.
- R13: While `ready` is low, reads and writes are ignored. No cell changes and `dq_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 1 | Write data bit |
| dq_out | output | 1 | Read data or test pass/fail bit (0 when not driven) |
| dq_oe | output | 1 | Output enable for the data pin |
| ready | output | 1 | Start-up and initialisation complete |
| test_active | output | 1 | Parallel test mode latched |

## Verification
The hardest state to reach from the ports is a test-mode read of a four-cell group whose cells disagree. Test-mode writes always make a group uniform, so a mismatch can only come from normal-mode writes made before entry. The stimulus therefore writes a deliberately mixed group and a uniform group in normal mode, then enters test mode and reads both. It then runs random test-mode reads and writes over groups that were filled randomly beforehand. Readiness gating is reached by issuing refreshes inside the start-up window, accesses and a test-entry attempt before the count completes, and then exactly the remaining refreshes.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    // Cycle tracker states, advanced on sampled strobe edges.
    typedef enum logic [1:0] {
        CY_IDLE,
        CY_ROW,
        CY_ACCESS,
        CY_CBR
    } cyc_state_e;

    // One-cycle event pulses produced by the cycle classifier.
    typedef struct packed {
        logic cbr;       // column-before-row refresh recognised
        logic cbr_test;  // ... with write enable low
        logic ror;       // row-only refresh completed
        logic acc_go;    // column strobe fell inside an open row
        logic acc_wr;    // that access is a write
    } cyc_evt_t;

    function automatic logic quad_same(input logic [3:0] q);
        return (q == 4'b0000) || (q == 4'b1111);
    endfunction

endpackage

// File: rtl/dcd_sync.sv
module dcd_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) pipe[0] <= RST_VAL;
                else     pipe[0] <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) pipe <= {STAGES{RST_VAL}};
                else     pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/dcd_classify.sv
module dcd_classify
    import dcd_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output cyc_evt_t          evt,
    output logic [ADDR_W-1:0] row_q
);

    cyc_state_e st, st_nxt;
    logic       ras_prev, cas_prev;
    logic       ras_fall, ras_rise, cas_fall;

    assign ras_fall = ras_prev & ~ras_n;
    assign ras_rise = ~ras_prev & ras_n;
    assign cas_fall = cas_prev & ~cas_n;

    always_comb begin
        evt    = '0;
        st_nxt = st;
        unique case (st)
            CY_IDLE: begin
                if (ras_fall) begin
                    if (!cas_n) begin
                        evt.cbr      = 1'b1;
                        evt.cbr_test = ~we_n;
                        st_nxt       = CY_CBR;
                    end else begin
                        st_nxt = CY_ROW;
                    end
                end
            end
            CY_ROW: begin
                if (ras_rise) begin
                    evt.ror = 1'b1;
                    st_nxt  = CY_IDLE;
                end else if (cas_fall) begin
                    evt.acc_go = 1'b1;
                    evt.acc_wr = ~we_n;
                    st_nxt     = CY_ACCESS;
                end
            end
            CY_ACCESS: begin
                if (ras_rise) begin
                    st_nxt = CY_IDLE;
                end else if (cas_fall) begin
                    evt.acc_go = 1'b1;
                    evt.acc_wr = ~we_n;
                end
            end
            CY_CBR: begin
                if (ras_rise) st_nxt = CY_IDLE;
            end
            default: st_nxt = CY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= CY_IDLE;
            ras_prev <= 1'b1;
            cas_prev <= 1'b1;
            row_q    <= '0;
        end else begin
            st       <= st_nxt;
            ras_prev <= ras_n;
            cas_prev <= cas_n;
            if (st == CY_IDLE && ras_fall && cas_n) row_q <= addr;
        end
    end

    // R3: a refresh cycle never turns into an array access
    p_cbr_no_access_r3: assert property (@(posedge clk) disable iff (rst)
        (st == CY_CBR) |-> !evt.acc_go);

    // R4: a row-only refresh always returns the tracker to idle
    p_ror_to_idle_r4: assert property (@(posedge clk) disable iff (rst)
        evt.ror |=> (st == CY_IDLE));

endmodule

// File: rtl/dcd_init_track.sv
module dcd_init_track #(
    parameter int STARTUP_CYC = 40000,
    parameter int INIT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic refresh,
    output logic ready
);

    localparam int WW = $clog2(STARTUP_CYC + 1);
    localparam int CW = $clog2(INIT_CYCLES + 1);

    logic [WW-1:0] wait_cnt;
    logic [CW-1:0] init_cnt;
    logic          wait_done;

    assign wait_done = (wait_cnt == WW'(STARTUP_CYC));
    assign ready     = (init_cnt == CW'(INIT_CYCLES));

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_cnt <= '0;
            init_cnt <= '0;
        end else begin
            if (!wait_done) wait_cnt <= wait_cnt + 1'b1;
            if (wait_done && refresh && !ready) init_cnt <= init_cnt + 1'b1;
        end
    end

    // R1: readiness never precedes the start-up interval
    p_ready_after_wait_r1: assert property (@(posedge clk) disable iff (rst)
        ready |-> wait_done);

    // R2: readiness is sticky
    p_ready_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

endmodule

// File: rtl/dcd_store_port.sv
module dcd_store_port
    import dcd_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_go,
    input  logic              acc_wr,
    input  logic              enable,
    input  logic              test,
    input  logic [ADDR_W-1:0] row,
    input  logic [ADDR_W-1:0] col,
    input  logic              cas_n,
    input  logic              din,
    output logic              dout,
    output logic              oe
);

    localparam int IW    = 2 * ADDR_W;
    localparam int DEPTH = 1 << IW;

    logic [DEPTH-1:0] mem;
    logic [IW-1:0]    idx, base;
    logic [3:0]       quad;
    logic             go, data_q, oe_q, pend_q;

    assign idx  = {row, col};
    assign base = idx & ~IW'(3);
    assign quad = mem[base +: 4];
    assign go   = acc_go & enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (go && acc_wr) begin
            if (test) mem[base +: 4] <= {4{din}};
            else      mem[idx]       <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= 1'b0;
            oe_q   <= 1'b0;
            pend_q <= 1'b0;
        end else if (go && !acc_wr) begin
            data_q <= test ? quad_same(quad) : mem[idx];
            oe_q   <= !test;
            pend_q <= test;
        end else if (go || cas_n) begin
            oe_q   <= 1'b0;
            pend_q <= 1'b0;
        end else if (pend_q) begin
            oe_q   <= 1'b1;
            pend_q <= 1'b0;
        end
    end

    assign dout = data_q & oe_q;
    assign oe   = oe_q;

    // R6: output released once the column strobe is high
    p_oe_cas_high_r6: assert property (@(posedge clk) disable iff (rst)
        cas_n |=> !oe);

    // R6: writes never drive the pin
    p_write_no_oe_r6: assert property (@(posedge clk) disable iff (rst)
        (go && acc_wr) |=> !oe);

    // R12: test read holds the pin off for the first cycle
    p_test_delay_r12: assert property (@(posedge clk) disable iff (rst)
        (go && !acc_wr && test) |=> !oe);

    // R13: no access starts the output while disabled
    p_no_oe_disabled_r13: assert property (@(posedge clk) disable iff (rst)
        (!enable && !oe) |=> !oe);

endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int STARTUP_CYC = 40000,
    parameter int INIT_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dq_in,
    output logic              dq_out,
    output logic              dq_oe,
    output logic              ready,
    output logic              test_active
);

    localparam int SW = ADDR_W + 4;
    localparam logic [SW-1:0] SYNC_RST = {3'b111, {(ADDR_W + 1){1'b0}}};

    logic [SW-1:0]     raw_v, syn_v;
    logic              s_ras, s_cas, s_we, s_dq;
    logic [ADDR_W-1:0] s_addr, row_q;
    cyc_evt_t          evt;
    logic              test_q;

    assign raw_v  = {ras_n, cas_n, we_n, dq_in, addr};
    assign s_ras  = syn_v[SW-1];
    assign s_cas  = syn_v[SW-2];
    assign s_we   = syn_v[SW-3];
    assign s_dq   = syn_v[ADDR_W];
    assign s_addr = syn_v[ADDR_W-1:0];

    dcd_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (raw_v),
        .q   (syn_v)
    );

    dcd_classify #(.ADDR_W(ADDR_W)) cls_i (
        .clk   (clk),
        .rst   (rst),
        .ras_n (s_ras),
        .cas_n (s_cas),
        .we_n  (s_we),
        .addr  (s_addr),
        .evt   (evt),
        .row_q (row_q)
    );

    dcd_init_track #(.STARTUP_CYC(STARTUP_CYC), .INIT_CYCLES(INIT_CYCLES)) init_i (
        .clk     (clk),
        .rst     (rst),
        .refresh (evt.cbr | evt.ror),
        .ready   (ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            test_q <= 1'b0;
        end else if (evt.cbr && evt.cbr_test && ready) begin
            test_q <= 1'b1;
        end else if (evt.ror || (evt.cbr && !evt.cbr_test)) begin
            test_q <= 1'b0;
        end
    end

    assign test_active = test_q;

    dcd_store_port #(.ADDR_W(ADDR_W)) store_i (
        .clk    (clk),
        .rst    (rst),
        .acc_go (evt.acc_go),
        .acc_wr (evt.acc_wr),
        .enable (ready),
        .test   (test_q),
        .row    (row_q),
        .col    (s_addr),
        .cas_n  (s_cas),
        .din    (s_dq),
        .dout   (dq_out),
        .oe     (dq_oe)
    );

    // R7: test mode only exists on a ready device
    p_test_needs_ready_r7: assert property (@(posedge clk) disable iff (rst)
        test_active |-> ready);

    // R9: row-only refresh always leaves test mode
    p_ror_exits_r9: assert property (@(posedge clk) disable iff (rst)
        evt.ror |=> !test_active);

    // R8: test mode holds through accesses
    p_test_held_r8: assert property (@(posedge clk) disable iff (rst)
        (test_active && evt.acc_go) |=> test_active);

    // R13: nothing is driven before readiness
    p_oe_needs_ready_r13: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !dq_oe);

endmodule

// File: tb/dram_cycle_decoder_tb_top.sv
`timescale 1ns/1ps
module dram_cycle_decoder_tb_top;

    localparam int AW    = 3;
    localparam int SYNC  = 2;
    localparam int START = 64;
    localparam int INITN = 8;
    localparam int CELLS = 1 << (2 * AW);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dq_in = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          dq_out, dq_oe, ready, test_active;

    int  n_run = 0, n_fail = 0;
    bit  ref_mem [CELLS];
    bit  ref_test = 1'b0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    dram_cycle_decoder #(
        .ADDR_W(AW), .SYNC_STAGES(SYNC), .STARTUP_CYC(START), .INIT_CYCLES(INITN)
    ) dut_i (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .ready(ready), .test_active(test_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit exp_read(input int idx);
        int b;
        b = idx & ~3;
        if (ref_test)
            return (ref_mem[b] == ref_mem[b+1]) && (ref_mem[b] == ref_mem[b+2]) &&
                   (ref_mem[b] == ref_mem[b+3]);
        return ref_mem[idx];
    endfunction

    task automatic do_ror(input logic [AW-1:0] row);
        addr = row; ras_n = 1'b0;
        wait_n(4);
        ras_n = 1'b1;
        wait_n(4);
    endtask

    task automatic do_cbr(input bit we);
        cas_n = 1'b0; we_n = we;
        wait_n(4);
        ras_n = 1'b0;
        wait_n(4);
        ras_n = 1'b1;
        wait_n(2);
        cas_n = 1'b1; we_n = 1'b1;
        wait_n(4);
    endtask

    task automatic do_wr(input logic [AW-1:0] row, input logic [AW-1:0] col,
                         input bit d, input bit check_oe);
        addr = row; ras_n = 1'b0;
        wait_n(3);
        addr = col; we_n = 1'b0; dq_in = d; cas_n = 1'b0;
        wait_n(5);
        if (check_oe) chk(dq_oe == 1'b0, "R6 oe during write", int'(dq_oe), 0);
        cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1;
        wait_n(4);
    endtask

    task automatic do_rd(input logic [AW-1:0] row, input logic [AW-1:0] col,
                         output int lat, output bit dq);
        addr = row; ras_n = 1'b0;
        wait_n(3);
        addr = col; cas_n = 1'b0;
        lat = 99; dq = 1'b0;
        for (int i = 1; i <= 8; i++) begin
            @(posedge clk); #1;
            if (dq_oe) begin
                lat = i; dq = dq_out;
                break;
            end
        end
        @(negedge clk);
        cas_n = 1'b1; ras_n = 1'b1;
        wait_n(4);
        chk(dq_oe == 1'b0, "R6 oe low after CAS high", int'(dq_oe), 0);
    endtask

    // write in either mode, with reference update
    task automatic ref_wr(input logic [AW-1:0] row, input logic [AW-1:0] col, input bit d,
                          input bit check_oe);
        int idx;
        idx = {row, col};
        do_wr(row, col, d, check_oe);
        if (ref_test) begin
            for (int k = 0; k < 4; k++) ref_mem[(idx & ~3) + k] = d;
        end else begin
            ref_mem[idx] = d;
        end
    endtask

    task automatic ref_rd(input logic [AW-1:0] row, input logic [AW-1:0] col, input string req);
        int lat; bit dq; bit e; int el;
        e  = exp_read({row, col});
        el = ref_test ? SYNC + 2 : SYNC + 1;
        do_rd(row, col, lat, dq);
        chk(dq == e, req, int'(dq), int'(e));
        chk(lat == el, ref_test ? "R12 test read latency" : "R6 read latency", lat, el);
    endtask

    initial begin
        int lat; bit dq;
        void'($urandom(32'd5813));
        for (int i = 0; i < CELLS; i++) ref_mem[i] = 1'b0;
        repeat (3) @(negedge clk);
        chk(ready == 1'b0, "R1 ready low in reset", int'(ready), 0);
        chk(dq_oe == 1'b0, "R6 oe low in reset", int'(dq_oe), 0);
        chk(test_active == 1'b0, "R9 test clear in reset", int'(test_active), 0);
        rst = 1'b0;

        // R1/R4: refreshes inside the start-up window do not count
        for (int i = 0; i < 3; i++) do_ror(AW'(i));
        chk(ready == 1'b0, "R1 startup refreshes", int'(ready), 0);
        wait_n(START);

        // R13: accesses before readiness are ignored
        do_wr(3'd2, 3'd3, 1'b1, 1'b0);
        do_rd(3'd2, 3'd3, lat, dq);
        chk(lat == 99, "R13 no read before ready", lat, 99);

        // R7: test entry ignored before ready (this counts as refresh 1)
        do_cbr(1'b0);
        chk(test_active == 1'b0, "R7 no entry before ready", int'(test_active), 0);
        for (int i = 0; i < 6; i++) begin
            if (i % 2 == 0) do_ror(AW'(i));
            else            do_cbr(1'b1);
        end
        chk(ready == 1'b0, "R1 seven refreshes", int'(ready), 0);
        do_ror(3'd7);
        chk(ready == 1'b1, "R1 eighth refresh", int'(ready), 1);

        ref_rd(3'd2, 3'd3, "R13 pre-ready write dropped");

        // fill the array randomly (R5)
        for (int i = 0; i < CELLS; i++) begin
            ref_wr(AW'(i >> AW), AW'(i), 1'($urandom % 2), i < 3);
        end
        // mixed and uniform groups for R10
        ref_wr(3'd5, 3'd0, 1'b1, 1'b0);
        ref_wr(3'd5, 3'd1, 1'b0, 1'b0);
        ref_wr(3'd5, 3'd2, 1'b1, 1'b0);
        ref_wr(3'd5, 3'd3, 1'b1, 1'b0);
        for (int c = 4; c < 8; c++) ref_wr(3'd6, AW'(c), 1'b1, 1'b0);

        for (int i = 0; i < 40; i++) begin
            ref_rd(AW'($urandom % 8), AW'($urandom % 8), "R5 normal read data");
        end

        do_ror(3'd3);
        chk(ready == 1'b1, "R2 ready sticky", int'(ready), 1);
        chk(test_active == 1'b0, "R4 refresh keeps normal mode", int'(test_active), 0);

        do_cbr(1'b0);
        ref_test = 1'b1;
        chk(test_active == 1'b1, "R7 test entry", int'(test_active), 1);

        ref_rd(3'd5, 3'd2, "R10 mixed group reads 0");
        ref_rd(3'd6, 3'd5, "R10 uniform group reads 1");

        for (int i = 0; i < 30; i++) begin
            if ($urandom % 2 == 0)
                ref_wr(AW'($urandom % 8), AW'($urandom % 8), 1'($urandom % 2), i < 2);
            else
                ref_rd(AW'($urandom % 8), AW'($urandom % 8), "R10 test read");
        end
        chk(test_active == 1'b1, "R8 test mode held", int'(test_active), 1);

        do_ror(3'd1);
        ref_test = 1'b0;
        chk(test_active == 1'b0, "R9 exit by row-only refresh", int'(test_active), 0);

        for (int i = 0; i < 12; i++) begin
            ref_rd(AW'($urandom % 8), AW'($urandom % 8), "R11 cells after test writes");
        end

        do_cbr(1'b0);
        ref_test = 1'b1;
        chk(test_active == 1'b1, "R7 re-entry", int'(test_active), 1);
        do_cbr(1'b1);
        ref_test = 1'b0;
        chk(test_active == 1'b0, "R9 exit by CBR with WE high", int'(test_active), 0);
        ref_rd(3'd6, 3'd4, "R9 normal read after exit");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule